// File: doc/BRIEF.md
# 4B/5B Transmit Coder with Error-Code Test Mode and Scrambler Bypass

This block is the transmit coding stage of a 100 Mb/s Fast Ethernet PCS. Once per five symbol clocks it takes one 4-bit transmit nibble, together with the transmit-enable and transmit-error qualifiers, and turns it into a 5-bit code group. Normal operation frames each packet itself. The first two enabled nibble slots become the start delimiter. The slots after the last enabled nibble become the end delimiter. Idle fills the line between frames. The code group leaves as a serial symbol stream, MSB first, through an 11-bit stream cipher.

Two control inputs change the behaviour. The error-code test input makes every nibble flagged with transmit-error pass through a fixed alternate table. That table produces deliberately invalid code groups, as well as the control groups, so that a downstream decoder can be exercised. The scrambler-off input bypasses the transmit cipher and the receive decipher together. Both ciphers are also bypassed whenever the port is not in 100 Mb/s mode. A receive-side decipher lane runs in step with the transmit cipher. It holds the bypass path of the receive direction.

Top module: `tx45_pcs_tx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it goes high, `o_nib_take` is 1 and the serial output carries the Idle group 11111 (scrambled only if the cipher is active). The frame state starts at idle.
- R2: `o_nib_take` is high in exactly one cycle out of every five. The nibble inputs are sampled on the clock edge that ends that cycle. The resulting 5-bit group appears on the serial line MSB first during the next five cycles. Its last bit shares a cycle with the next `o_nib_take`.
- R3: For a data slot in a frame (transmit-enable high, transmit-error low), the nibble 0..F is coded as 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101, in nibble order.
- R4: The first slot with transmit-enable high after idle sends J (11000). The next enabled slot sends K (10001). Data coding starts with the third slot.
- R5: The first slot with transmit-enable low after a frame sends T (01101), and the slot after it sends R (00111). These two slots are sent even if the frame ended in the K slot. After them the line sends Idle (11111) until transmit-enable rises again.
- R6: With the test input low, a data slot with transmit-error high sends H (00100). Transmit-error has no effect on the J, K, T, R or Idle slots.
- R7: With the test input high, any slot with transmit-error high is coded from its nibble alone: 0000→00000, 0001→00001, 0010→00010, 0011→00011, 0100→00100, 0101→00101, 0110→00110, 0111→00111, 1000→10000, 1001→11001, 1010→01100, 1011→01000, 1100→01101, 1101→10001, 1110→11000, 1111→11111. The frame state still advances on transmit-enable. With transmit-error low, the test input has no effect.
- R8: A test input that is high never changes a slot whose transmit-error is low. A test input that is low never selects the alternate table.
- R9: When the cipher is active (scrambler-off 0 and 100 Mb/s mode 1), each serial bit is the code bit XORed with a key bit. The key comes from an 11-bit LFSR, x^11 + x^9 + 1. The LFSR loads the seed parameter (default 0x5A5) on reset and steps every symbol clock. Key = s[10] XOR s[8], and the next state is {s[9:0], key}.
- R10: When scrambler-off is 1 or 100 Mb/s mode is 0, both the transmit serial output and the receive output pass their input bits unchanged.
- R11: The receive output is the receive input bit XORed with the same key sequence, under the same enable. Looping the transmit output back to the receive input returns the unscrambled code bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_txd | input | 4 | Transmit nibble |
| i_tx_en | input | 1 | Transmit enable for the nibble |
| i_tx_er | input | 1 | Transmit error for the nibble |
| i_err_test | input | 1 | Selects the alternate code table for error-flagged nibbles |
| i_scr_off | input | 1 | Bypasses transmit cipher and receive decipher |
| i_speed100 | input | 1 | 1 in 100 Mb/s mode; cipher bypassed when 0 |
| o_nib_take | output | 1 | High in the cycle whose closing edge samples the nibble |
| o_tx_sym | output | 1 | Serial transmit symbol bit |
| i_rx_sym | input | 1 | Serial receive symbol bit |
| o_rx_sym | output | 1 | Deciphered receive symbol bit |

## Verification
The bench builds the block with its default parameters: a 5-bit code group, an 11-bit cipher with taps at 11 and 9, and seed 0x5A5. The transmit output is looped back to the receive input. At this size every one of the 16 nibbles can be swept through the standard table and through the alternate table. Each frame boundary, an aborted one-slot frame included, is crossed with transmit-error set and with it clear. A full-length frame is also run with the cipher active. There, each serial bit is compared against a key stream that the bench steps itself, and the loopback shows that the decipher restores the plain code groups.

// File: rtl/tx45_pkg.sv
// Shared widths, code-group constants, frame states and the two
// nibble-to-group translations used by the transmit coder.
package tx45_pkg;

    localparam int NIB_W = 4;
    localparam int CG_W  = 5;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [CG_W-1:0]  cg_t;

    localparam cg_t CG_IDLE = 5'b11111;
    localparam cg_t CG_J    = 5'b11000;
    localparam cg_t CG_K    = 5'b10001;
    localparam cg_t CG_T    = 5'b01101;
    localparam cg_t CG_R    = 5'b00111;
    localparam cg_t CG_H    = 5'b00100;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_K    = 2'd1,
        FR_DATA = 2'd2,
        FR_R    = 2'd3
    } frame_e;

    // Standard data translation for one nibble.
    function automatic cg_t data_cg(input nib_t n);
        cg_t c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

    // Alternate translation used in error-code test mode.
    function automatic cg_t test_cg(input nib_t n);
        cg_t c;
        case (n)
            4'h0: c = 5'b00000;
            4'h1: c = 5'b00001;
            4'h2: c = 5'b00010;
            4'h3: c = 5'b00011;
            4'h4: c = CG_H;
            4'h5: c = 5'b00101;
            4'h6: c = 5'b00110;
            4'h7: c = CG_R;
            4'h8: c = 5'b10000;
            4'h9: c = 5'b11001;
            4'hA: c = 5'b01100;
            4'hB: c = 5'b01000;
            4'hC: c = CG_T;
            4'hD: c = CG_K;
            4'hE: c = CG_J;
            default: c = CG_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tx45_coder.sv
// Frame-aware nibble coder. It picks the code group for the current
// nibble slot from the frame state and the qualifiers, and advances the
// frame state on each load strobe.
// Assumes: load is high in exactly the cycle whose closing edge consumes
// the nibble; the inputs are stable in that cycle.
module tx45_coder
    import tx45_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  nib_t txd,
    input  logic tx_en,
    input  logic tx_er,
    input  logic err_test,
    output cg_t  code
);

    frame_e st, st_nxt;
    cg_t    cg_norm;

    // Framing decision: the next state and the group for normal coding.
    always_comb begin
        st_nxt  = st;
        cg_norm = CG_IDLE;
        unique case (st)
            FR_IDLE: begin
                if (tx_en) begin
                    cg_norm = CG_J;
                    st_nxt  = FR_K;
                end
            end
            FR_K: begin
                if (tx_en) begin
                    cg_norm = CG_K;
                    st_nxt  = FR_DATA;
                end else begin
                    cg_norm = CG_T;
                    st_nxt  = FR_R;
                end
            end
            FR_DATA: begin
                if (tx_en) begin
                    cg_norm = tx_er ? CG_H : data_cg(txd);
                end else begin
                    cg_norm = CG_T;
                    st_nxt  = FR_R;
                end
            end
            FR_R: begin
                cg_norm = CG_R;
                st_nxt  = FR_IDLE;
            end
            default: begin
                cg_norm = CG_IDLE;
                st_nxt  = FR_IDLE;
            end
        endcase
    end

    // Test-mode override: an error-flagged nibble uses the alternate table.
    always_comb begin
        code = (err_test && tx_er) ? test_cg(txd) : cg_norm;
    end

    // Frame state register, advanced once per nibble slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= FR_IDLE;
        end else if (load) begin
            st <= st_nxt;
        end
    end

    // R5: the R slot always returns the frame to idle.
    p_r_then_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && st == FR_R) |=> (st == FR_IDLE));

    // R4: the K slot leads either into data or straight into the end delimiter.
    p_k_slot_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && st == FR_K) |=> (st == FR_DATA || st == FR_R));

    // R5: the state can only leave idle through the K slot.
    p_idle_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FR_IDLE) |=> (st == FR_IDLE || st == FR_K));

endmodule

// File: rtl/tx45_serializer.sv
// Symbol-slot timer and parallel-to-serial shifter. A phase counter
// marks one load cycle in every CG_W cycles; at the edge that closes the
// load cycle the code group enters the shifter, which then presents it
// MSB first.
// Assumes: code_in is valid whenever load is high.
module tx45_serializer #(
    parameter int CG_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CG_W-1:0] code_in,
    output logic            load,
    output logic            ser_bit
);

    localparam int PH_W = (CG_W > 1) ? $clog2(CG_W) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CG_W - 1);

    logic [PH_W-1:0] ph;
    logic [CG_W-1:0] sh;

    assign load    = (ph == '0);
    assign ser_bit = sh[CG_W-1];

    // Phase counter: counts 0..CG_W-1 and wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (ph == PH_LAST) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    // Shift register: loads a group on the load edge, otherwise shifts left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '1;
        end else if (load) begin
            sh <= code_in;
        end else begin
            sh <= {sh[CG_W-2:0], 1'b1};
        end
    end

    // R2: load strobes never occur in consecutive cycles.
    p_take_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // R2: the phase counter stays inside one code-group length.
    p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph <= PH_LAST);

endmodule

// File: rtl/tx45_cipher.sv
// One stream-cipher lane: a free-running Fibonacci LFSR whose key bit is
// XORed onto the passing serial bit when enabled. Used twice, for
// transmit scrambling and receive descrambling, so both lanes share one
// key sequence from reset.
// Assumes: SEED is nonzero; TAP_HI > TAP_LO >= 1; TAP_HI == LFSR_W.
module tx45_cipher #(
    parameter int               LFSR_W = 11,
    parameter int               TAP_HI = 11,
    parameter int               TAP_LO = 9,
    parameter logic [LFSR_W-1:0] SEED  = 11'h5A5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic i_en,
    input  logic i_bit,
    output logic o_bit
);

    logic [LFSR_W-1:0] lfsr;
    logic              key;

    assign key   = lfsr[TAP_HI-1] ^ lfsr[TAP_LO-1];
    assign o_bit = i_en ? (i_bit ^ key) : i_bit;

    // Key generator: steps every symbol clock, regardless of bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr <= SEED;
        end else begin
            lfsr <= {lfsr[LFSR_W-2:0], key};
        end
    end

    // R9: a nonzero seed never collapses to the all-zero lock-up state.
    p_lfsr_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);

endmodule

// File: rtl/tx45_pcs_tx.sv
// Top of the 4B/5B transmit coder. It wires the frame coder to the
// serializer and runs two cipher lanes: lane 0 scrambles the transmit
// stream and lane 1 descrambles the receive stream. Both lanes are
// bypassed when scrambling is switched off or the port is not at 100 Mb/s.
// Assumes: one symbol clock drives both directions.
module tx45_pcs_tx #(
    parameter int                LFSR_W = 11,
    parameter int                TAP_HI = 11,
    parameter int                TAP_LO = 9,
    parameter logic [LFSR_W-1:0] SEED   = 11'h5A5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] i_txd,
    input  logic       i_tx_en,
    input  logic       i_tx_er,
    input  logic       i_err_test,
    input  logic       i_scr_off,
    input  logic       i_speed100,
    output logic       o_nib_take,
    output logic       o_tx_sym,
    input  logic       i_rx_sym,
    output logic       o_rx_sym
);
    import tx45_pkg::*;

    localparam int N_LANE = 2;

    cg_t               code;
    logic              load;
    logic              ser_bit;
    logic              scr_en;
    logic [N_LANE-1:0] lane_in;
    logic [N_LANE-1:0] lane_out;

    assign scr_en     = !i_scr_off && i_speed100;
    assign o_nib_take = load;
    assign lane_in    = {i_rx_sym, ser_bit};
    assign o_tx_sym   = lane_out[0];
    assign o_rx_sym   = lane_out[1];

    tx45_coder u_coder (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .txd      (i_txd),
        .tx_en    (i_tx_en),
        .tx_er    (i_tx_er),
        .err_test (i_err_test),
        .code     (code)
    );

    tx45_serializer #(.CG_W(CG_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_in (code),
        .load    (load),
        .ser_bit (ser_bit)
    );

    // One cipher lane per direction, sharing the enable and seed.
    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        tx45_cipher #(
            .LFSR_W (LFSR_W),
            .TAP_HI (TAP_HI),
            .TAP_LO (TAP_LO),
            .SEED   (SEED)
        ) u_cipher (
            .clk   (clk),
            .rst_n (rst_n),
            .i_en  (scr_en),
            .i_bit (lane_in[g]),
            .o_bit (lane_out[g])
        );
    end

    // R10: with the cipher bypassed, both directions are transparent.
    p_bypass_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !scr_en |-> (o_tx_sym == ser_bit && o_rx_sym == i_rx_sym));

    // R11: both lanes apply the same key in every cycle.
    p_lane_key_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (o_tx_sym ^ ser_bit) == (o_rx_sym ^ i_rx_sym));

endmodule

// File: tb/tx45_pcs_tx_tb_top.sv
module tx45_pcs_tx_tb_top;

    localparam int          CLK_PERIOD = 8;
    localparam int          WD_CYCLES  = 100000;
    localparam logic [10:0] SEED       = 11'h5A5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] txd;
    logic       tx_en, tx_er, err_test, scr_off, speed100;
    logic       nib_take, tx_sym, rx_sym, rx_out;

    int vec_cnt  = 0;
    int miss_cnt = 0;
    bit done     = 1'b0;

    logic [10:0] lfsr_m;
    int          bst;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Loopback of the transmit stream into the receive lane.
    assign rx_sym = tx_sym;

    tx45_pcs_tx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .i_txd      (txd),
        .i_tx_en    (tx_en),
        .i_tx_er    (tx_er),
        .i_err_test (err_test),
        .i_scr_off  (scr_off),
        .i_speed100 (speed100),
        .o_nib_take (nib_take),
        .o_tx_sym   (tx_sym),
        .i_rx_sym   (rx_sym),
        .o_rx_sym   (rx_out)
    );

    // Independent key-stream model stepped at each symbol clock.
    always @(posedge clk) begin
        if (!rst_n) lfsr_m <= SEED;
        else        lfsr_m <= {lfsr_m[9:0], lfsr_m[10] ^ lfsr_m[8]};
    end

    function automatic logic [4:0] std_code(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    function automatic logic [4:0] alt_code(input logic [3:0] n);
        case (n)
            4'h0: return 5'b00000; 4'h1: return 5'b00001;
            4'h2: return 5'b00010; 4'h3: return 5'b00011;
            4'h4: return 5'b00100; 4'h5: return 5'b00101;
            4'h6: return 5'b00110; 4'h7: return 5'b00111;
            4'h8: return 5'b10000; 4'h9: return 5'b11001;
            4'hA: return 5'b01100; 4'hB: return 5'b01000;
            4'hC: return 5'b01101; 4'hD: return 5'b10001;
            4'hE: return 5'b11000; default: return 5'b11111;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic act, input logic expv);
        vec_cnt++;
        if (act !== expv) begin
            miss_cnt++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, expv);
        end
    endtask

    // One nibble slot: called at a negedge with nib_take high, ends at the
    // negedge of the next take. Expected group follows R3..R7.
    task automatic slot(input logic en, input logic er, input logic [3:0] d,
                        input string req);
        logic [4:0] exp;
        int         nxt;
        logic       act_scr;
        nxt = bst;
        case (bst)
            0: begin exp = en ? 5'b11000 : 5'b11111; nxt = en ? 1 : 0; end
            1: begin exp = en ? 5'b10001 : 5'b01101; nxt = en ? 2 : 3; end
            2: begin
                if (en) exp = er ? 5'b00100 : std_code(d);
                else    begin exp = 5'b01101; nxt = 3; end
            end
            default: begin exp = 5'b00111; nxt = 0; end
        endcase
        if (err_test && er) exp = alt_code(d);
        bst   = nxt;
        txd   = d;
        tx_en = en;
        tx_er = er;
        act_scr = !scr_off && speed100;
        for (int k = 4; k >= 0; k--) begin
            @(negedge clk);
            check(req, "tx bit", tx_sym, exp[k] ^ (act_scr & (lfsr_m[10] ^ lfsr_m[8])));
            check("R11", "rx loopback", rx_out, exp[k]);
            check("R2", "take", nib_take, (k == 0));
        end
    endtask

    // Watchdog: a hang is a failed check and still reports.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            miss_cnt++;
            $display("FAIL R2 watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; txd = '0; tx_en = 0; tx_er = 0;
        err_test = 0; scr_off = 1; speed100 = 1; bst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports.
        check("R1", "take in reset", nib_take, 1'b1);
        check("R1", "idle in reset", tx_sym, 1'b1);
        rst_n = 1'b1;
        check("R1", "take after reset", nib_take, 1'b1);
        check("R1", "idle after reset", tx_sym, 1'b1);
        repeat (3) slot(0, 0, 4'h0, "R1");

        // R4, R3, R5: full frame sweeping every data nibble.
        slot(1, 0, 4'h5, "R4");
        slot(1, 0, 4'h5, "R4");
        for (int n = 0; n < 16; n++) slot(1, 0, 4'(n), "R3");
        slot(0, 0, 4'h0, "R5");
        slot(0, 0, 4'h0, "R5");
        slot(0, 0, 4'h0, "R5");

        // R5: frame aborted after the J slot.
        slot(1, 0, 4'h0, "R5");
        slot(0, 0, 4'h0, "R5");
        slot(0, 0, 4'h0, "R5");
        slot(0, 0, 4'h0, "R5");

        // R6, R8: error flag in normal mode.
        slot(0, 1, 4'h3, "R6");
        slot(1, 1, 4'h9, "R6");
        slot(1, 1, 4'h9, "R6");
        slot(1, 1, 4'h9, "R6");
        slot(1, 0, 4'h9, "R6");
        slot(0, 1, 4'h9, "R6");
        slot(0, 1, 4'h9, "R6");
        slot(0, 1, 4'h9, "R8");

        // R7, R8: error-code test mode, outside and inside a frame.
        err_test = 1;
        for (int n = 0; n < 16; n++) slot(0, 1, 4'(n), "R7");
        slot(0, 0, 4'h7, "R8");
        slot(1, 0, 4'h0, "R7");
        slot(1, 0, 4'h0, "R7");
        for (int n = 0; n < 16; n++) begin
            slot(1, 1, 4'(n), "R7");
            slot(1, 0, 4'(n), "R8");
        end
        slot(0, 0, 4'h0, "R7");
        slot(0, 0, 4'h0, "R7");
        err_test = 0;

        // R9, R11: cipher active, full frame through the loopback.
        scr_off = 0;
        slot(0, 0, 4'h0, "R9");
        slot(0, 0, 4'h0, "R9");
        slot(1, 0, 4'h0, "R9");
        slot(1, 0, 4'h0, "R9");
        for (int n = 0; n < 16; n++) slot(1, 0, 4'(15 - n), "R9");
        slot(0, 0, 4'h0, "R9");
        slot(0, 0, 4'h0, "R9");
        slot(0, 0, 4'h0, "R9");

        // R10: not at 100 Mb/s, the cipher is bypassed.
        speed100 = 0;
        slot(0, 0, 4'h0, "R10");
        slot(1, 0, 4'hA, "R10");
        slot(1, 0, 4'hA, "R10");
        slot(1, 0, 4'hA, "R10");
        slot(0, 0, 4'h0, "R10");
        slot(0, 0, 4'h0, "R10");
        speed100 = 1;
        scr_off  = 1;
        slot(0, 0, 4'h0, "R10");
        slot(0, 0, 4'h0, "R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end

endmodule